// File: doc/BRIEF.md
# Multi-mode 16-bit PWM timer

This block is a 16-bit waveform timer whose counting pattern comes from a 4-bit mode code. The counter runs as a sawtooth for fast PWM, as a triangle for the two dual-slope PWM variants, or as a clear-on-compare counter. Its upper limit (TOP) is a fixed 10-bit constant, the software-written capture register, or the active value of compare channel 0. Each compare channel has a software-visible buffer and an active value, and the buffer reaches the active value at a point that the mode chooses. The block also raises an overflow flag at a point that the mode chooses, keeps one match flag per channel, and drives one waveform output per channel.

Counting is gated by a 3-bit clock select. Zero stops the counter, one advances it on every clock, and the other codes advance it only on cycles where the external prescaled `tick` input is high. Software reaches the counter, the capture register, the compare buffers and the flag-clear port through a single write strobe with a 3-bit address.

Top module: `pwm16_timer`

## Requirements
- R1: After reset the count is 0, every flag is 0, every waveform output is 0, and the capture register and all compare values are 0.
- R2: clk_sel = 0 holds the count; clk_sel = 1 advances on every clock; clk_sel = 2..7 advances only in cycles where tick is 1.
- R3: Mode codes 7, 14 and 15 count 0,1,..,TOP,0 with TOP = 0x03FF, the capture register or the active compare 0 respectively; the overflow flag is set by the advance taken while the count is at or above TOP (the wrap).
- R4: In modes 7, 14 and 15 a waveform output goes to 1 on the wrap advance and to 0 on an advance taken while the count equals that channel's active compare; when both happen on one advance the output becomes 1.
- R5: Modes 8 and 10 take TOP from the capture register, modes 9 and 11 from active compare 0; the count rises to TOP then falls to 0, turning at each end point (TOP, TOP-1 after the top; 0, 1 after the bottom); the overflow flag is set by an advance taken while the count is 0.
- R6: In modes 8 to 11 a match advance clears the channel output while counting up and sets it while counting down.
- R7: A compare write (address 2 + channel) lands in the buffer; in modes 7, 8, 9, 14 and 15 the buffer moves to the active value on the wrap advance (7, 14, 15) or on an advance at count 0 (8, 9); in modes 10 and 11 on the advance at TOP while counting up.
- R8: Mode 12 takes TOP from the capture register, applies compare writes immediately, toggles the channel output on each match advance, wraps after TOP or after 0xFFFF, and sets the overflow flag on an advance taken at 0xFFFF.
- R9: Mode codes 0 to 6 and 13 freeze the count, the flags and the waveform outputs.
- R10: A write to address 0 loads the count and takes precedence over counting in that cycle; address 1 loads the capture register.
- R11: A channel match flag is set by an advance taken while the count equals that channel's active compare.
- R12: A write to address 7 clears the overflow flag where data bit 0 is 1 and match flag n where data bit n+1 is 1; a flag set in the same cycle stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled count enable used by clk_sel 2..7 |
| clk_sel | input | 3 | Counting source select, 0 stops |
| mode | input | 4 | Waveform mode code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 count, 1 capture, 2+n compare n, 7 flag clear) |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Overflow flag |
| match_flag | output | 2 | Per-channel compare match flags |
| wave | output | 2 | Per-channel waveform outputs |

## Verification
The hardest state to reach is the clear-on-compare counter sitting above its TOP, where it must run on to 0xFFFF before wrapping and raise the overflow flag only there; the stimulus writes the counter directly to a value just under 0xFFFF while the capture limit is small. Buffer transfers in the dual-slope modes are reached by rewriting a compare value part way through a slope, so the old value must keep governing the waveform until the mode's transfer point. Set-versus-clear collisions on the flags come from writing the clear address on every cycle of a short fast-PWM period, so clears meet wrap and match events.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;

   typedef enum logic [1:0] {
      SHP_IDLE = 2'd0,
      SHP_SAW  = 2'd1,
      SHP_TRI  = 2'd2,
      SHP_CLR  = 2'd3
   } shape_e;

   typedef enum logic [1:0] {
      TSRC_FIXED = 2'd0,
      TSRC_CAP   = 2'd1,
      TSRC_CMPA  = 2'd2
   } tsrc_e;

   typedef enum logic [1:0] {
      PT_TOP    = 2'd0,
      PT_BOT    = 2'd1,
      PT_MAX    = 2'd2,
      PT_ALWAYS = 2'd3
   } point_e;

   typedef struct packed {
      shape_e shape;
      tsrc_e  tsrc;
      point_e load_pt;
      point_e flag_pt;
   } mode_cfg_t;

endpackage

// File: rtl/pwm16_mode_dec.sv
module pwm16_mode_dec #(
   parameter bit HAS_FIXED = 1'b1
) (
   input  logic                  [3:0] mode,
   output pwm16_pkg::mode_cfg_t        cfg
);
   import pwm16_pkg::*;

   mode_cfg_t base;

   always_comb begin
      base = '{shape: SHP_IDLE, tsrc: TSRC_CAP, load_pt: PT_MAX, flag_pt: PT_MAX};
      case (mode)
         4'd7:  base = '{shape: SHP_SAW, tsrc: TSRC_FIXED, load_pt: PT_TOP,    flag_pt: PT_TOP};
         4'd8:  base = '{shape: SHP_TRI, tsrc: TSRC_CAP,   load_pt: PT_BOT,    flag_pt: PT_BOT};
         4'd9:  base = '{shape: SHP_TRI, tsrc: TSRC_CMPA,  load_pt: PT_BOT,    flag_pt: PT_BOT};
         4'd10: base = '{shape: SHP_TRI, tsrc: TSRC_CAP,   load_pt: PT_TOP,    flag_pt: PT_BOT};
         4'd11: base = '{shape: SHP_TRI, tsrc: TSRC_CMPA,  load_pt: PT_TOP,    flag_pt: PT_BOT};
         4'd12: base = '{shape: SHP_CLR, tsrc: TSRC_CAP,   load_pt: PT_ALWAYS, flag_pt: PT_MAX};
         4'd14: base = '{shape: SHP_SAW, tsrc: TSRC_CAP,   load_pt: PT_TOP,    flag_pt: PT_TOP};
         4'd15: base = '{shape: SHP_SAW, tsrc: TSRC_CMPA,  load_pt: PT_TOP,    flag_pt: PT_TOP};
         default: ;
      endcase
   end

   generate
      if (HAS_FIXED) begin : g_fixed_on
         assign cfg = base;
      end else begin : g_fixed_off
         always_comb begin
            cfg = base;
            if (mode == 4'd7) cfg.shape = SHP_IDLE;
         end
      end
   endgenerate

endmodule

// File: rtl/pwm16_counter.sv
module pwm16_counter #(
   parameter int W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  pwm16_pkg::shape_e       shape,
   input  logic                    adv,
   input  logic [W-1:0]            top,
   input  logic                    wr,
   input  logic [W-1:0]            wr_data,
   output logic [W-1:0]            cnt,
   output logic                    up,
   output logic                    top_evt,
   output logic                    bot_evt,
   output logic                    max_evt
);
   import pwm16_pkg::*;

   localparam logic [W-1:0] MAXV = {W{1'b1}};
   localparam logic [W-1:0] ONE  = W'(1);

   logic top_hit;

   always_comb begin
      top_hit = (shape == SHP_CLR) ? (cnt == top) : (cnt >= top);
      top_evt = adv && up && top_hit;
      bot_evt = adv && (cnt == '0);
      max_evt = adv && (cnt == MAXV);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         up  <= 1'b1;
      end else begin
         if (shape != SHP_TRI) up <= 1'b1;
         if (wr) begin
            cnt <= wr_data;
         end else if (adv) begin
            case (shape)
               SHP_SAW: cnt <= top_evt ? '0 : cnt + ONE;
               SHP_CLR: cnt <= (top_evt || max_evt) ? '0 : cnt + ONE;
               SHP_TRI: begin
                  if (up) begin
                     if (top_hit) begin
                        up  <= 1'b0;
                        cnt <= (top == '0) ? '0 : top - ONE;
                     end else begin
                        cnt <= cnt + ONE;
                     end
                  end else begin
                     if (cnt == '0) begin
                        up  <= 1'b1;
                        cnt <= (top == '0) ? '0 : ONE;
                     end else begin
                        cnt <= cnt - ONE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !wr) |=> $stable(cnt)); // R2
   AST_SAW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && shape == SHP_SAW && !top_hit) |=> (cnt == $past(cnt) + ONE)); // R3
   AST_TRI_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && shape == SHP_TRI && up && top_hit && top != '0) |=> (!up && cnt == $past(top) - ONE)); // R5
   AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (cnt == $past(wr_data))); // R10

endmodule

// File: rtl/pwm16_channel.sv
module pwm16_channel #(
   parameter int W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  pwm16_pkg::shape_e       shape,
   input  logic                    adv,
   input  logic                    up,
   input  logic [W-1:0]            cnt,
   input  logic                    top_evt,
   input  logic                    ld_now,
   input  logic                    ld_evt,
   input  logic                    wr,
   input  logic [W-1:0]            wr_data,
   output logic [W-1:0]            act,
   output logic                    match,
   output logic                    wave
);
   import pwm16_pkg::*;

   logic [W-1:0] cbuf;

   assign match = adv && (cnt == act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cbuf <= '0;
         act  <= '0;
         wave <= 1'b0;
      end else begin
         if (wr) cbuf <= wr_data;
         if (ld_now)      act <= wr ? wr_data : cbuf;
         else if (ld_evt) act <= cbuf;
         if (adv) begin
            case (shape)
               SHP_SAW: begin
                  if (top_evt)    wave <= 1'b1;
                  else if (match) wave <= 1'b0;
               end
               SHP_TRI: if (match) wave <= !up;
               SHP_CLR: if (match) wave <= !wave;
               default: ;
            endcase
         end
      end
   end

   AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(wave)); // R9
   AST_CMP_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_now && !wr) |=> (act == $past(cbuf))); // R8
   AST_SAW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (shape == SHP_SAW && top_evt) |=> wave); // R4
   AST_ACT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_now && !ld_evt) |=> $stable(act)); // R7

endmodule

// File: rtl/pwm16_timer.sv
module pwm16_timer #(
   parameter int W          = 16,
   parameter int NUM_CH     = 2,
   parameter int FIXED_BITS = 10,
   parameter int CS_W       = 3,
   parameter int ADDR_W     = 3,
   parameter bit HAS_FIXED  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [CS_W-1:0]   clk_sel,
   input  logic [3:0]        mode,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [W-1:0]      wr_data,
   output logic [W-1:0]      count,
   output logic              ovf_flag,
   output logic [NUM_CH-1:0] match_flag,
   output logic [NUM_CH-1:0] wave
);
   import pwm16_pkg::*;

   localparam logic [W-1:0]      FIXED_TOP = W'((1 << FIXED_BITS) - 1);
   localparam logic [ADDR_W-1:0] A_CNT     = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_CAP     = ADDR_W'(1);
   localparam int                A_CMP0    = 2;
   localparam logic [ADDR_W-1:0] A_FCLR    = ADDR_W'((1 << ADDR_W) - 1);

   generate
      if (FIXED_BITS >= W) begin : g_chk_fixed
         $error("FIXED_BITS must be below W");
      end
      if (NUM_CH < 1 || A_CMP0 + NUM_CH > (1 << ADDR_W) - 1) begin : g_chk_ch
         $error("NUM_CH does not fit the write address map");
      end
      if (CS_W < 2) begin : g_chk_cs
         $error("CS_W must be at least 2");
      end
   endgenerate

   mode_cfg_t    cfg;
   logic         run_sel, wr_cnt, fclr, adv;
   logic         up, top_evt, bot_evt, max_evt, ovf_evt, ld_now, ld_evt;
   logic [W-1:0] cap_q, top_val;
   logic [W-1:0] act [NUM_CH];
   logic [NUM_CH-1:0] match;

   pwm16_mode_dec #(.HAS_FIXED(HAS_FIXED)) u_dec (
      .mode (mode),
      .cfg  (cfg)
   );

   assign run_sel = (clk_sel == CS_W'(1)) || ((clk_sel > CS_W'(1)) && tick);
   assign wr_cnt  = wr_en && (wr_addr == A_CNT);
   assign fclr    = wr_en && (wr_addr == A_FCLR);
   assign adv     = run_sel && (cfg.shape != SHP_IDLE) && !wr_cnt;

   always_comb begin
      case (cfg.tsrc)
         TSRC_FIXED: top_val = FIXED_TOP;
         TSRC_CMPA:  top_val = act[0];
         default:    top_val = cap_q;
      endcase
   end

   always_comb begin
      ld_now = (cfg.load_pt == PT_ALWAYS);
      case (cfg.load_pt)
         PT_TOP:  ld_evt = top_evt;
         PT_BOT:  ld_evt = bot_evt;
         PT_MAX:  ld_evt = max_evt;
         default: ld_evt = 1'b0;
      endcase
      case (cfg.flag_pt)
         PT_TOP:  ovf_evt = top_evt;
         PT_BOT:  ovf_evt = bot_evt;
         PT_MAX:  ovf_evt = max_evt;
         default: ovf_evt = 1'b0;
      endcase
   end

   pwm16_counter #(.W(W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .shape   (cfg.shape),
      .adv     (adv),
      .top     (top_val),
      .wr      (wr_cnt),
      .wr_data (wr_data),
      .cnt     (count),
      .up      (up),
      .top_evt (top_evt),
      .bot_evt (bot_evt),
      .max_evt (max_evt)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic wr_cmp;
         assign wr_cmp = wr_en && (wr_addr == ADDR_W'(A_CMP0 + i));

         pwm16_channel #(.W(W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .shape   (cfg.shape),
            .adv     (adv),
            .up      (up),
            .cnt     (count),
            .top_evt (top_evt),
            .ld_now  (ld_now),
            .ld_evt  (ld_evt),
            .wr      (wr_cmp),
            .wr_data (wr_data),
            .act     (act[i]),
            .match   (match[i]),
            .wave    (wave[i])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) match_flag[i] <= 1'b0;
            else        match_flag[i] <= match[i] || (match_flag[i] && !(fclr && wr_data[i+1]));
         end

         AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            match[i] |=> match_flag[i]); // R11
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q    <= '0;
         ovf_flag <= 1'b0;
      end else begin
         if (wr_en && wr_addr == A_CAP) cap_q <= wr_data;
         ovf_flag <= ovf_evt || (ovf_flag && !(fclr && wr_data[0]));
      end
   end

   AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_flag); // R12
   AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (fclr && wr_data[0] && !ovf_evt) |=> !ovf_flag); // R12
   AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.shape == SHP_IDLE && !ovf_flag) |=> !ovf_flag); // R9

endmodule

// File: tb/pwm16_timer_tb.sv
`timescale 1ns/1ps
module pwm16_timer_tb;

   localparam int NCH = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick;
   logic [2:0]  clk_sel;
   logic [3:0]  mode;
   logic        wr_en;
   logic [2:0]  wr_addr;
   logic [15:0] wr_data;
   logic [15:0] count;
   logic        ovf_flag;
   logic [1:0]  match_flag;
   logic [1:0]  wave;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   pwm16_timer u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .clk_sel    (clk_sel),
      .mode       (mode),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .count      (count),
      .ovf_flag   (ovf_flag),
      .match_flag (match_flag),
      .wave       (wave)
   );

   // expected state
   logic [15:0] e_cnt, e_cap;
   logic        e_up, e_ovf;
   logic [1:0]  e_mf, e_wave;
   logic [15:0] e_buf [NCH];
   logic [15:0] e_act [NCH];

   task automatic model_reset();
      e_cnt = '0; e_cap = '0; e_up = 1'b1; e_ovf = 1'b0; e_mf = '0; e_wave = '0;
      for (int i = 0; i < NCH; i++) begin e_buf[i] = '0; e_act[i] = '0; end
   endtask

   // shape: 0 frozen, 1 sawtooth, 2 triangle, 3 clear-on-compare
   // top source: 0 fixed 0x3FF, 1 capture, 2 compare 0
   // points: 0 top/wrap, 1 count zero, 2 0xFFFF, 3 immediate
   task automatic model_next();
      int sh, ts, lp, fp;
      logic [15:0] top, ncnt;
      logic nup, adv, hit, te, be, me, ld, wcnt, fclr, oe, m;
      logic [15:0] nact [NCH];
      logic [1:0]  nwave, nmf;
      sh = 0; ts = 1; lp = 2; fp = 2;
      case (mode)
         4'd7:  begin sh = 1; ts = 0; lp = 0; fp = 0; end
         4'd8:  begin sh = 2; ts = 1; lp = 1; fp = 1; end
         4'd9:  begin sh = 2; ts = 2; lp = 1; fp = 1; end
         4'd10: begin sh = 2; ts = 1; lp = 0; fp = 1; end
         4'd11: begin sh = 2; ts = 2; lp = 0; fp = 1; end
         4'd12: begin sh = 3; ts = 1; lp = 3; fp = 2; end
         4'd14: begin sh = 1; ts = 1; lp = 0; fp = 0; end
         4'd15: begin sh = 1; ts = 2; lp = 0; fp = 0; end
         default: ;
      endcase
      wcnt = wr_en && wr_addr == 3'd0;
      fclr = wr_en && wr_addr == 3'd7;
      adv  = ((clk_sel == 3'd1) || (clk_sel > 3'd1 && tick)) && sh != 0 && !wcnt;
      top  = (ts == 0) ? 16'h03FF : (ts == 1) ? e_cap : e_act[0];
      hit  = (sh == 3) ? (e_cnt == top) : (e_cnt >= top);
      te   = adv && e_up && hit;
      be   = adv && e_cnt == 16'h0000;
      me   = adv && e_cnt == 16'hFFFF;
      ld   = (lp == 0) ? te : (lp == 1) ? be : (lp == 2) ? me : 1'b0;
      oe   = (fp == 0) ? te : (fp == 1) ? be : me;
      ncnt = e_cnt;
      nup  = (sh != 2) ? 1'b1 : e_up;
      if (wcnt) ncnt = wr_data;
      else if (adv) begin
         if (sh == 1) ncnt = te ? 16'h0 : e_cnt + 16'd1;
         else if (sh == 3) ncnt = (te || me) ? 16'h0 : e_cnt + 16'd1;
         else if (sh == 2) begin
            if (e_up) begin
               if (hit) begin nup = 1'b0; ncnt = (top == 0) ? 16'h0 : top - 16'd1; end
               else ncnt = e_cnt + 16'd1;
            end else begin
               if (e_cnt == 0) begin nup = 1'b1; ncnt = (top == 0) ? 16'h0 : 16'd1; end
               else ncnt = e_cnt - 16'd1;
            end
         end
      end
      nwave = e_wave;
      nmf = e_mf;
      for (int i = 0; i < NCH; i++) begin
         logic wc;
         wc = wr_en && wr_addr == 3'(2 + i);
         m = adv && e_cnt == e_act[i];
         if (adv) begin
            if (sh == 1) begin
               if (te) nwave[i] = 1'b1; else if (m) nwave[i] = 1'b0;
            end else if (sh == 2) begin
               if (m) nwave[i] = !e_up;
            end else if (sh == 3) begin
               if (m) nwave[i] = !e_wave[i];
            end
         end
         nact[i] = e_act[i];
         if (lp == 3) nact[i] = wc ? wr_data : e_buf[i];
         else if (ld) nact[i] = e_buf[i];
         if (wc) e_buf[i] = wr_data;
         nmf[i] = m || (e_mf[i] && !(fclr && wr_data[i+1]));
      end
      e_ovf = oe || (e_ovf && !(fclr && wr_data[0]));
      if (wr_en && wr_addr == 3'd1) e_cap = wr_data;
      for (int i = 0; i < NCH; i++) e_act[i] = nact[i];
      e_cnt = ncnt; e_up = nup; e_wave = nwave; e_mf = nmf;
   endtask

   task automatic compare(input string tag);
      logic [20:0] a, e;
      a = {count, ovf_flag, match_flag, wave};
      e = {e_cnt, e_ovf, e_mf, e_wave};
      total++;
      if (a !== e) begin
         bad++;
         $display("FAIL %s mode=%0d {count,ovf,mflag,wave} actual=%h/%b/%b/%b expected=%h/%b/%b/%b",
                  tag, mode, count, ovf_flag, match_flag, wave, e_cnt, e_ovf, e_mf, e_wave);
      end
   endtask

   task automatic step(input string tag);
      model_next();
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic run(input int n, input string tag, input bit pat);
      for (int k = 0; k < n; k++) begin
         tick = pat ? (k % 3 == 0) : 1'b0;
         step(tag);
      end
      tick = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step(tag);
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      compare("R1");
   endtask

   initial begin
      rst_n = 1'b0; tick = 1'b0; clk_sel = '0; mode = '0;
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      model_reset();
      do_reset();

      // R2: clock select gating
      mode = 4'd14;
      wr(3'd1, 16'd9, "R2");
      clk_sel = 3'd0; run(6, "R2", 1'b0);
      clk_sel = 3'd3; run(30, "R2", 1'b1);
      clk_sel = 3'd7; run(12, "R2", 1'b0);
      clk_sel = 3'd1; run(12, "R2", 1'b0);

      // R4 / R11: fast PWM with capture TOP, compare swept over every value
      for (int c = 0; c <= 6; c++) begin
         do_reset();
         clk_sel = 3'd1; mode = 4'd14;
         wr(3'd1, 16'd5, "R3");
         wr(3'd3, 16'(c), "R4");
         wr(3'd2, 16'(6 - c), "R11");
         run(16, "R4 R11", 1'b0);
      end

      // R3: fixed 10-bit TOP
      do_reset();
      clk_sel = 3'd1; mode = 4'd7;
      wr(3'd2, 16'd100, "R3");
      wr(3'd3, 16'd1023, "R3");
      run(2100, "R3", 1'b0);

      // R3: TOP from compare 0
      do_reset();
      clk_sel = 3'd1; mode = 4'd15;
      wr(3'd2, 16'd6, "R3");
      wr(3'd3, 16'd2, "R3");
      run(24, "R3", 1'b0);

      // R5 / R6 / R7: dual-slope modes, compare sweep and mid-slope rewrite
      for (int m = 8; m <= 11; m++) begin
         for (int c = 0; c <= 7; c++) begin
            do_reset();
            clk_sel = 3'd1; mode = 4'(m);
            wr(3'd1, 16'd6, "R5");
            wr(3'd2, 16'd6, "R5");
            wr(3'd3, 16'(c), "R6");
            run(14 + c, "R5 R6", 1'b0);
            wr(3'd3, 16'((c + 3) % 8), "R7");
            run(22, "R7", 1'b0);
         end
      end

      // R8: clear-on-compare, immediate compare, run above TOP to 0xFFFF
      do_reset();
      clk_sel = 3'd1; mode = 4'd12;
      wr(3'd1, 16'd4, "R8");
      wr(3'd3, 16'd2, "R8");
      run(12, "R8", 1'b0);
      wr(3'd3, 16'd1, "R8");
      run(8, "R8", 1'b0);
      wr(3'd0, 16'hFFF0, "R8");
      run(24, "R8", 1'b0);

      // R9: unsupported codes freeze everything
      do_reset();
      clk_sel = 3'd1; mode = 4'd14;
      wr(3'd1, 16'd7, "R9");
      wr(3'd3, 16'd3, "R9");
      run(13, "R9", 1'b0);
      mode = 4'd13; run(8, "R9", 1'b0);
      mode = 4'd3;  run(5, "R9", 1'b0);
      mode = 4'd0;  run(5, "R9", 1'b0);
      mode = 4'd14; run(4, "R9", 1'b0);

      // R10: count write wins over counting
      wr(3'd0, 16'd3, "R10");
      run(3, "R10", 1'b0);
      wr(3'd0, 16'd6, "R10");
      run(6, "R10", 1'b0);

      // R12: flag clears colliding with set events
      do_reset();
      clk_sel = 3'd1; mode = 4'd14;
      wr(3'd1, 16'd3, "R12");
      wr(3'd3, 16'd1, "R12");
      run(6, "R12", 1'b0);
      for (int k = 0; k < 12; k++) wr(3'd7, 16'h0007, "R12");
      run(5, "R12", 1'b0);
      wr(3'd7, 16'h0002, "R12");
      wr(3'd7, 16'h0004, "R12");
      run(2, "R12", 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule